// File: doc/BRIEF.md
# Start-to-Response Timing Monitor

This block is a synthesizable protocol monitor that watches a one-bit start event and a one-bit response on a clocked interface. It flags a failure whenever the response breaks the timing rule chosen at build time. Two variants exist, selected by a parameter. In the exact-delay variant the response has to be true on precisely the DELAY-th rising edge after an accepted start. An optional check also flags a response that no start accounts for. In the window variant the response has to come on an edge between MIN_CKS and MAX_CKS after the start, both bounds inclusive.

Only one check is tracked at a time. A start seen while a check is open is not tracked separately and does not restart the count. All sampling happens on the rising edge. Reset is synchronous and active high, and nothing is sampled while `enable` is low.

The outputs are registered:
- a three-bit pulse vector: failure, a spare bit held at zero, and a start hit;
- a saturating count of reported failures;
- three sticky bits that record which kinds of failure have been seen.

Top module: `resp_timing_mon`

## Requirements
- R1: While `rst` is high at a rising edge, `fire`, `errCount` and `failSticky` are all zero on the following cycle.
- R2: In exact-delay mode, a start accepted at edge e0 is checked at edge e0+DELAY. If `testExpr` is low there, `fire[0]` is high for the cycle after that edge and `failSticky[0]` (late) is set. If it is high, nothing is flagged.
- R3: In exact-delay mode with the orphan check on, `testExpr` high at an edge that is not the check edge of an open check raises `fire[0]` and sets `failSticky[2]` (no start).
- R4: In exact-delay mode, a start seen while a check is open, including at its check edge, is ignored. It causes no later check.
- R5: In window mode, `testExpr` high at edge e0+k with MIN_CKS <= k <= MAX_CKS passes and closes the window. No failure follows.
- R6: In window mode, `testExpr` high at edge e0+k with k < MIN_CKS raises `fire[0]`, sets `failSticky[1]` (early) and closes the window.
- R7: In window mode, if `testExpr` stays low through edge e0+MAX_CKS, `fire[0]` is raised after that edge and `failSticky[0]` is set. The failure is not raised earlier.
- R8: In window mode, a start arriving while the window is open is ignored, and the failure edge stays tied to the first start. `testExpr` high while no window is open is not a failure.
- R9: `fire[2]` pulses for one cycle after every edge that samples `startEvt` high with `enable` high, whether or not that start is accepted. `fire[1]` is always zero.
- R10: At an edge where `enable` is low, nothing is sampled. The open check keeps its elapsed count, and no bit of `fire` is raised.
- R11: `errCount` rises by one per failure edge up to REPORT_LIMIT and then holds. `fire[0]` keeps pulsing after the limit is reached.
- R12: `fire[0]` is a one-cycle pulse per failure. `failSticky` bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Monitor samples only while high |
| startEvt | input | 1 | Start event |
| testExpr | input | 1 | Response expression |
| fire | output | 3 | [0] failure pulse, [1] zero, [2] start hit pulse |
| errCount | output | CNT_W | Saturating count of reported failures |
| failSticky | output | 3 | [0] late, [1] early, [2] no start |

## Verification
The bench builds two copies of the block. The first is an exact-delay copy with DELAY 2, the orphan check on and a report limit of 4. A delay of two leaves one intermediate edge inside every open check, so a second start there and a frozen count under a low `enable` both become visible. The second is a window copy with MIN_CKS 2, MAX_CKS 4 and a report limit of 3. This lets responses at both inclusive bounds and one below the lower bound be tried. Three window failures then reach the report limit, so saturation is covered within a short run.

// File: rtl/resp_timing_pkg.sv
package resp_timing_pkg;

  typedef enum logic {
    CHK_IDLE = 1'b0,
    CHK_OPEN = 1'b1
  } chkState_t;

  // strobes from control to timer and reporting
  typedef struct packed {
    logic openWin;     // load elapsed count with 1
    logic stepCnt;     // advance elapsed count
    logic covHit;      // start sampled while enabled
    logic failLate;
    logic failEarly;
    logic failOrphan;
  } chkStrobe_t;

  localparam int FIRE_W      = 3;
  localparam int FIRE_FAIL   = 0;
  localparam int FIRE_SPARE  = 1;
  localparam int FIRE_COV    = 2;

  localparam int STICKY_W      = 3;
  localparam int STICKY_LATE   = 0;
  localparam int STICKY_EARLY  = 1;
  localparam int STICKY_ORPHAN = 2;

endpackage

// File: rtl/resp_timing_timer.sv
module resp_timing_timer
  import resp_timing_pkg::*;
#(
  parameter bit WINDOW_MODE = 1'b0,
  parameter int DELAY       = 1,
  parameter int MIN_CKS     = 2,
  parameter int MAX_CKS     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  chkStrobe_t strobe,
  output logic       atTarget,
  output logic       belowMin
);

  localparam int TARGET = WINDOW_MODE ? MAX_CKS : DELAY;
  localparam int LOWER  = WINDOW_MODE ? MIN_CKS : DELAY;
  localparam int ELW    = $clog2(TARGET + 1) + 1;

  logic [ELW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (strobe.openWin) begin
      elapsed <= ELW'(1);
    end else if (strobe.stepCnt) begin
      elapsed <= elapsed + ELW'(1);
    end
  end

  generate
    if (WINDOW_MODE) begin : g_window
      assign atTarget = (elapsed == ELW'(MAX_CKS));
      assign belowMin = (elapsed <  ELW'(MIN_CKS));
    end else begin : g_fixed
      assign atTarget = (elapsed == ELW'(DELAY));
      assign belowMin = (elapsed <  ELW'(LOWER));
    end
  endgenerate

  // R7
  elapsed_bound_chk: assert property (@(posedge clk) disable iff (rst)
    elapsed <= ELW'(TARGET));

  // R10
  elapsed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.openWin && !strobe.stepCnt |=> $stable(elapsed));

endmodule

// File: rtl/resp_timing_ctrl.sv
module resp_timing_ctrl
  import resp_timing_pkg::*;
#(
  parameter bit WINDOW_MODE  = 1'b0,
  parameter bit CHECK_ORPHAN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       startEvt,
  input  logic       testExpr,
  input  logic       atTarget,
  input  logic       belowMin,
  output chkStrobe_t strobe
);

  chkState_t state;
  logic      closeWin;

  generate
    if (WINDOW_MODE) begin : g_window
      always_comb begin
        strobe   = '0;
        closeWin = 1'b0;
        strobe.covHit = enable && startEvt;
        if (enable) begin
          if (state == CHK_OPEN) begin
            if (testExpr) begin
              closeWin         = 1'b1;
              strobe.failEarly = belowMin;
            end else if (atTarget) begin
              closeWin        = 1'b1;
              strobe.failLate = 1'b1;
            end else begin
              strobe.stepCnt = 1'b1;
            end
          end else if (startEvt) begin
            strobe.openWin = 1'b1;
          end
        end
      end
    end else begin : g_fixed
      always_comb begin
        strobe   = '0;
        closeWin = 1'b0;
        strobe.covHit = enable && startEvt;
        if (enable) begin
          if (state == CHK_OPEN) begin
            if (atTarget) begin
              closeWin        = 1'b1;
              strobe.failLate = !testExpr;
            end else if (belowMin) begin
              strobe.stepCnt    = 1'b1;
              strobe.failOrphan = CHECK_ORPHAN && testExpr;
            end else begin
              closeWin = 1'b1;
            end
          end else begin
            strobe.failOrphan = CHECK_ORPHAN && testExpr;
            strobe.openWin    = startEvt;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CHK_IDLE;
    end else if (strobe.openWin) begin
      state <= CHK_OPEN;
    end else if (closeWin) begin
      state <= CHK_IDLE;
    end
  end

  // R4
  open_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == CHK_OPEN) |-> $past(startEvt && enable));

  // R10
  disabled_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(state));

  // R12
  one_fail_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.failLate, strobe.failEarly, strobe.failOrphan}));

endmodule

// File: rtl/resp_timing_report.sv
module resp_timing_report
  import resp_timing_pkg::*;
#(
  parameter int REPORT_LIMIT = 4,
  parameter int CNT_W        = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  chkStrobe_t          strobe,
  output logic [FIRE_W-1:0]   fire,
  output logic [CNT_W-1:0]    errCount,
  output logic [STICKY_W-1:0] failSticky
);

  logic anyFail;
  logic belowLimit;

  assign anyFail    = strobe.failLate || strobe.failEarly || strobe.failOrphan;
  assign belowLimit = (errCount < CNT_W'(REPORT_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      fire       <= '0;
      errCount   <= '0;
      failSticky <= '0;
    end else begin
      fire[FIRE_FAIL]  <= anyFail;
      fire[FIRE_SPARE] <= 1'b0;
      fire[FIRE_COV]   <= strobe.covHit;
      if (anyFail && belowLimit) begin
        errCount <= errCount + CNT_W'(1);
      end
      if (strobe.failLate)   failSticky[STICKY_LATE]   <= 1'b1;
      if (strobe.failEarly)  failSticky[STICKY_EARLY]  <= 1'b1;
      if (strobe.failOrphan) failSticky[STICKY_ORPHAN] <= 1'b1;
    end
  end

  // R11
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    errCount <= CNT_W'(REPORT_LIMIT));

  // R11
  count_needs_fail_chk: assert property (@(posedge clk) disable iff (rst)
    errCount != $past(errCount) |-> fire[FIRE_FAIL]);

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (failSticky & $past(failSticky)) == $past(failSticky));

endmodule

// File: rtl/resp_timing_mon.sv
module resp_timing_mon
  import resp_timing_pkg::*;
#(
  parameter bit WINDOW_MODE  = 1'b0,
  parameter int DELAY        = 1,
  parameter int MIN_CKS      = 2,
  parameter int MAX_CKS      = 4,
  parameter bit CHECK_ORPHAN = 1'b1,
  parameter int REPORT_LIMIT = 4,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             startEvt,
  input  logic             testExpr,
  output logic [2:0]       fire,
  output logic [CNT_W-1:0] errCount,
  output logic [2:0]       failSticky
);

  chkStrobe_t strobe;
  logic       atTarget;
  logic       belowMin;

  resp_timing_ctrl #(
    .WINDOW_MODE (WINDOW_MODE),
    .CHECK_ORPHAN(CHECK_ORPHAN)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .startEvt(startEvt),
    .testExpr(testExpr),
    .atTarget(atTarget),
    .belowMin(belowMin),
    .strobe  (strobe)
  );

  resp_timing_timer #(
    .WINDOW_MODE(WINDOW_MODE),
    .DELAY      (DELAY),
    .MIN_CKS    (MIN_CKS),
    .MAX_CKS    (MAX_CKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .atTarget(atTarget),
    .belowMin(belowMin)
  );

  resp_timing_report #(
    .REPORT_LIMIT(REPORT_LIMIT),
    .CNT_W       (CNT_W)
  ) u_report (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .fire      (fire),
    .errCount  (errCount),
    .failSticky(failSticky)
  );

endmodule

// File: tb/tb_resp_timing_mon.sv
`timescale 1ns/1ps
module tb_resp_timing_mon;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic startF = 1'b0, testF = 1'b0, startW = 1'b0, testW = 1'b0;
  logic [2:0] fireF, fireW, stickF, stickW;
  logic [7:0] cntF, cntW;

  int nTests = 0;
  int nFail  = 0;
  int expF   = 0;
  int expW   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  resp_timing_mon #(.WINDOW_MODE(1'b0), .DELAY(2), .CHECK_ORPHAN(1'b1),
                    .REPORT_LIMIT(4), .CNT_W(8)) dut (
    .clk(clk), .rst(rst), .enable(enable), .startEvt(startF), .testExpr(testF),
    .fire(fireF), .errCount(cntF), .failSticky(stickF));

  resp_timing_mon #(.WINDOW_MODE(1'b1), .MIN_CKS(2), .MAX_CKS(4),
                    .CHECK_ORPHAN(1'b0), .REPORT_LIMIT(3), .CNT_W(8)) dutWin (
    .clk(clk), .rst(rst), .enable(enable), .startEvt(startW), .testExpr(testW),
    .fire(fireW), .errCount(cntW), .failSticky(stickW));

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tickF(input logic s, input logic t);
    startF = s; testF = t;
    @(negedge clk);
    startF = 1'b0; testF = 1'b0;
  endtask

  task automatic tickW(input logic s, input logic t);
    startW = s; testW = t;
    @(negedge clk);
    startW = 1'b0; testW = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 fixed fire", int'(fireF), 0);
    check("R1 fixed count", int'(cntF), 0);
    check("R1 fixed sticky", int'(stickF), 0);
    check("R1 window fire", int'(fireW), 0);
    check("R1 window count", int'(cntW), 0);
    check("R1 window sticky", int'(stickW), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fix_pass;
    tickF(1, 0);
    check("R9 start hit", int'(fireF), 4);
    tickF(0, 0);
    check("R2 mid check quiet", int'(fireF[0]), 0);
    tickF(0, 1);
    check("R2 on-time response passes", int'(fireF[0]), 0);
    check("R2 count unchanged", int'(cntF), expF);
  endtask

  task automatic t_fix_late;
    tickF(1, 0);
    tickF(0, 0);
    tickF(0, 0);
    expF++;
    check("R2 missing response fails", int'(fireF[0]), 1);
    check("R2 late sticky", int'(stickF[0]), 1);
    check("R11 count step", int'(cntF), expF);
    tickF(0, 0);
    check("R12 pulse one cycle", int'(fireF[0]), 0);
    check("R12 sticky held", int'(stickF[0]), 1);
  endtask

  task automatic t_fix_orphan;
    tickF(0, 1);
    expF++;
    check("R3 response without start", int'(fireF[0]), 1);
    check("R3 orphan sticky", int'(stickF[2]), 1);
    check("R3 count", int'(cntF), expF);
    tickF(0, 0);
  endtask

  task automatic t_fix_overlap;
    tickF(1, 0);
    tickF(1, 0);
    check("R9 ignored start still hits", int'(fireF[2]), 1);
    tickF(0, 1);
    check("R4 first check passes", int'(fireF[0]), 0);
    tickF(0, 0);
    check("R4 second start untracked", int'(fireF[0]), 0);
    tickF(0, 0);
    check("R4 no late check", int'(fireF[0]), 0);
    check("R4 count", int'(cntF), expF);
  endtask

  task automatic t_fix_enable;
    enable = 1'b0;
    tickF(1, 1);
    check("R10 disabled no fire", int'(fireF), 0);
    tickF(0, 0);
    tickF(0, 0);
    check("R10 no check opened", int'(fireF[0]), 0);
    enable = 1'b1;
    tickF(1, 0);
    enable = 1'b0;
    tickF(0, 0);
    tickF(0, 0);
    check("R10 frozen quiet", int'(fireF[0]), 0);
    enable = 1'b1;
    tickF(0, 0);
    check("R10 count resumes", int'(fireF[0]), 0);
    tickF(0, 1);
    check("R10 response after freeze passes", int'(fireF[0]), 0);
    check("R10 count", int'(cntF), expF);
  endtask

  task automatic t_win_idle;
    tickW(0, 1);
    check("R8 idle response ignored", int'(fireW[0]), 0);
    check("R8 idle sticky", int'(stickW), 0);
  endtask

  task automatic t_win_pass(input int k);
    tickW(1, 0);
    for (int i = 1; i < k; i++) begin
      tickW(0, 0);
      check("R5 quiet inside window", int'(fireW[0]), 0);
    end
    tickW(0, 1);
    check("R5 response in window passes", int'(fireW[0]), 0);
    tickW(0, 0);
    check("R5 window closed", int'(fireW[0]), 0);
    check("R5 count", int'(cntW), expW);
  endtask

  task automatic t_win_early;
    tickW(1, 0);
    tickW(0, 1);
    expW++;
    check("R6 early fails", int'(fireW[0]), 1);
    check("R6 early sticky", int'(stickW[1]), 1);
    check("R6 count", int'(cntW), expW);
    for (int i = 0; i < 5; i++) begin
      tickW(0, 0);
      check("R6 window closed after early", int'(fireW[0]), 0);
    end
  endtask

  task automatic t_win_late;
    tickW(1, 0);
    for (int i = 1; i < 4; i++) begin
      tickW(0, 0);
      check("R7 not before max", int'(fireW[0]), 0);
    end
    tickW(0, 0);
    expW++;
    check("R7 late at max", int'(fireW[0]), 1);
    check("R7 late sticky", int'(stickW[0]), 1);
    check("R7 count", int'(cntW), expW);
  endtask

  task automatic t_win_restart;
    tickW(1, 0);
    tickW(0, 0);
    tickW(1, 0);
    tickW(0, 0);
    check("R8 no early fire", int'(fireW[0]), 0);
    tickW(0, 0);
    expW++;
    check("R8 late tied to first start", int'(fireW[0]), 1);
    check("R8 count", int'(cntW), expW);
    tickW(0, 0);
    tickW(0, 0);
    check("R8 no second late", int'(fireW[0]), 0);
  endtask

  task automatic t_win_limit;
    tickW(1, 0);
    repeat (3) tickW(0, 0);
    tickW(0, 0);
    check("R11 fire beyond limit", int'(fireW[0]), 1);
    check("R11 count saturates", int'(cntW), 3);
    check("R9 spare bit zero", int'(fireW[1]), 0);
    tickW(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fix_pass();
    t_fix_late();
    t_fix_orphan();
    t_fix_overlap();
    t_fix_enable();
    t_win_idle();
    t_win_pass(2);
    t_win_pass(3);
    t_win_pass(4);
    t_win_early();
    t_win_late();
    t_win_restart();
    t_win_limit();
    t_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule